// File: doc/BRIEF.md
# Bank Timing Selector with Bus Turnaround

This block keeps the timing configuration for one bank of a static memory controller. It has two 32-bit timing words: a primary word and a write word. For each access it decides which word applies. When the extended-mode input is low, the primary word serves both reads and writes. When it is high, reads take the primary word and writes take the write word. The chosen word drives the `act_word` output. The 2-bit access mode decoded from it drives `act_mode`.

An access is requested by holding `req_valid` high, with `req_write` giving the direction and `req_mux` marking a memory that shares address and data lines. A request is granted in the same cycle whenever no turnaround gap is running.

A read from a multiplexed memory starts a programmable idle gap, so that the shared bus is released before the next address goes out. A request made during that gap waits and is granted in the first cycle after the gap ends.

Top module: `bank_timing_sel`

## Requirements
- R1: After reset, both timing words read back as 0x0FFF_FFFF.
- R2: Bits 31:30 of both timing words ignore written values and always read back as zero.
- R3: A configuration write with `cfg_sel`=0 changes only the primary word, and one with `cfg_sel`=1 changes only the write word. `cfg_rdata` shows the word selected by `cfg_sel`, updated in the cycle after the write.
- R4: With `ext_mode`=0, `act_word` equals the primary word for both reads and writes.
- R5: With `ext_mode`=1, `act_word` equals the primary word when `req_write`=0 and the write word when `req_write`=1.
- R6: With `ext_mode`=1, `act_mode` equals bits 29:28 of the selected word. The encodings are 00=A, 01=B, 10=C and 11=D. With `ext_mode`=0, `act_mode` is forced to 00 (mode A).
- R7: While no gap is running, `grant` equals `req_valid` in the same cycle. `grant` is never high without `req_valid`.
- R8: After a granted read (`req_write`=0) with `req_mux`=1, `grant` stays low for exactly T+1 cycles, where T is bits 19:16 of the primary word. This gives 1 to 16 cycles.
- R9: A granted write, or a granted read with `req_mux`=0, starts no gap. A request held in the next cycle is granted at once.
- R10: A request held through a gap is granted in the first cycle after the gap ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Timing word select for write and readback: 0 selects the primary word, 1 selects the write word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Readback of the selected timing word |
| ext_mode | input | 1 | Extended mode: separate write timing and decoded access mode |
| req_valid | input | 1 | Access request, held until granted |
| req_write | input | 1 | Access direction: 1 for write, 0 for read |
| req_mux | input | 1 | Target memory multiplexes address and data |
| grant | output | 1 | Request accepted this cycle |
| act_word | output | 32 | Timing word that applies to the current access |
| act_mode | output | 2 | Access mode that applies to the current access |

## Verification
The hardest situation to reach is a request that arrives during a turnaround gap and must be granted exactly one cycle after the gap ends. Reaching it needs a multiplexed read to be granted first, and the gap length is set through the turnaround field. The bench programs that field to 0, 5 and 15. It grants a multiplexed read and keeps a write request asserted through the gap. It then counts the idle cycles one by one and checks that the held request is granted in the cycle right after the last idle cycle. It also checks that the write granted at that point does not open a new gap.

// File: rtl/bts_pkg.sv
package bts_pkg;
    localparam int WORD_W   = 32;
    localparam int NUM_SETS = 2;
    localparam int SEL_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;
    localparam int MODE_LSB = 28;
    localparam int MODE_W   = 2;
    localparam int TURN_LSB = 16;
    localparam int TURN_W   = 4;
    localparam int GAP_W    = TURN_W + 1;
    localparam int RESV_W   = WORD_W - MODE_LSB - MODE_W;

    localparam logic [WORD_W-1:0] TIM_RESET = 32'h0FFF_FFFF;
    localparam logic [WORD_W-1:0] TIM_WMASK = {{RESV_W{1'b0}}, {(WORD_W-RESV_W){1'b1}}};

    typedef enum logic [MODE_W-1:0] {
        MODE_A = 2'b00,
        MODE_B = 2'b01,
        MODE_C = 2'b10,
        MODE_D = 2'b11
    } acc_mode_e;

    typedef struct packed {
        logic valid;
        logic write;
        logic mux;
    } acc_req_t;

    function automatic logic [TURN_W-1:0] turn_field(input logic [WORD_W-1:0] w);
        return w[TURN_LSB +: TURN_W];
    endfunction

    function automatic acc_mode_e mode_field(input logic [WORD_W-1:0] w);
        return acc_mode_e'(w[MODE_LSB +: MODE_W]);
    endfunction
endpackage

// File: rtl/bts_timing_regs.sv
module bts_timing_regs
    import bts_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             we,
    input  logic [SEL_W-1:0]                 sel,
    input  logic [WORD_W-1:0]                wdata,
    output logic [NUM_SETS-1:0][WORD_W-1:0]  words
);
    logic [WORD_W-1:0] q [NUM_SETS];

    always_ff @(posedge clk) begin
        for (int s = 0; s < NUM_SETS; s++) begin
            if (rst)
                q[s] <= TIM_RESET;
            else if (we && sel == SEL_W'(s))
                q[s] <= wdata & TIM_WMASK;
        end
    end

    always_comb begin
        for (int s = 0; s < NUM_SETS; s++)
            words[s] = q[s];
    end
endmodule

// File: rtl/bts_select.sv
module bts_select
    import bts_pkg::*;
(
    input  logic              ext_mode,
    input  logic              req_write,
    input  logic [WORD_W-1:0] prim_word,
    input  logic [WORD_W-1:0] wr_word,
    output logic [WORD_W-1:0] act_word,
    output acc_mode_e         act_mode
);
    always_comb begin
        act_word = (ext_mode && req_write) ? wr_word : prim_word;
        act_mode = ext_mode ? mode_field(act_word) : MODE_A;
    end
endmodule

// File: rtl/bts_gap_ctr.sv
module bts_gap_ctr
    import bts_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  acc_req_t          req,
    input  logic [TURN_W-1:0] turn,
    output logic              grant
);
    logic [GAP_W-1:0] cnt;
    logic             gap_idle;

    assign gap_idle = (cnt == '0);
    assign grant    = req.valid && gap_idle;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (grant && !req.write && req.mux)
            cnt <= GAP_W'(turn) + GAP_W'(1);
        else if (!gap_idle)
            cnt <= cnt - GAP_W'(1);
    end
endmodule

// File: rtl/bank_timing_sel.sv
module bank_timing_sel
    import bts_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic        cfg_sel,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        ext_mode,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        req_mux,
    output logic        grant,
    output logic [31:0] act_word,
    output logic [1:0]  act_mode
);
    logic [NUM_SETS-1:0][WORD_W-1:0] words;
    logic [WORD_W-1:0]               prim_word;
    logic [WORD_W-1:0]               wr_word;
    acc_mode_e                       mode_sel;
    acc_req_t                        req;

    bts_timing_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .sel   (SEL_W'(cfg_sel)),
        .wdata (cfg_wdata),
        .words (words)
    );

    assign prim_word = words[0];
    assign wr_word   = words[1];
    assign cfg_rdata = words[cfg_sel];

    bts_select u_sel (
        .ext_mode  (ext_mode),
        .req_write (req_write),
        .prim_word (prim_word),
        .wr_word   (wr_word),
        .act_word  (act_word),
        .act_mode  (mode_sel)
    );

    assign act_mode = mode_sel;

    assign req = '{valid: req_valid, write: req_write, mux: req_mux};

    bts_gap_ctr u_gap (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .turn  (turn_field(act_word)),
        .grant (grant)
    );
endmodule

// File: rtl/bts_chk.sv
module bts_chk (
    input logic        clk,
    input logic        rst,
    input logic        ext_mode,
    input logic        req_valid,
    input logic        req_write,
    input logic        req_mux,
    input logic        grant,
    input logic [1:0]  act_mode,
    input logic [31:0] act_word,
    input logic [31:0] prim_word,
    input logic [31:0] wr_word,
    input logic [31:0] cfg_rdata
);
    // R2
    resv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[31:30] == 2'b00);

    // R4
    shared_set_chk: assert property (@(posedge clk) disable iff (rst)
        !ext_mode |-> act_word == prim_word);

    // R5
    split_set_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_mode && req_write) |-> act_word == wr_word);

    // R6
    mode_forced_chk: assert property (@(posedge clk) disable iff (rst)
        !ext_mode |-> act_mode == 2'b00);

    // R7
    grant_req_chk: assert property (@(posedge clk) disable iff (rst)
        grant |-> req_valid);

    // R8
    gap_start_chk: assert property (@(posedge clk) disable iff (rst)
        (grant && !req_write && req_mux) |=> !grant);

    // R9
    no_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (grant && (req_write || !req_mux)) ##1 req_valid |-> grant);
endmodule

bind bank_timing_sel bts_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ext_mode  (ext_mode),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_mux   (req_mux),
    .grant     (grant),
    .act_mode  (act_mode),
    .act_word  (act_word),
    .prim_word (prim_word),
    .wr_word   (wr_word),
    .cfg_rdata (cfg_rdata)
);

// File: tb/bank_timing_sel_test.sv
module bank_timing_sel_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic        cfg_sel;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        ext_mode;
    logic        req_valid;
    logic        req_write;
    logic        req_mux;
    logic        grant;
    logic [31:0] act_word;
    logic [1:0]  act_mode;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    bank_timing_sel uut (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .ext_mode  (ext_mode),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_mux   (req_mux),
        .grant     (grant),
        .act_word  (act_word),
        .act_mode  (act_mode)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr_cfg(input logic sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_cfg(input logic sel, input string req, input logic [31:0] exp);
        cfg_sel = sel;
        #1;
        chk(req, cfg_rdata, exp);
    endtask

    task automatic t_reset();
        rd_cfg(1'b0, "R1 primary reset", 32'h0FFF_FFFF);
        rd_cfg(1'b1, "R1 write-word reset", 32'h0FFF_FFFF);
        chk("R7 idle grant", {31'b0, grant}, 32'h0);
    endtask

    task automatic t_reserved();
        wr_cfg(1'b0, 32'hFFFF_FFFF);
        rd_cfg(1'b0, "R2 primary top bits", 32'h3FFF_FFFF);
        wr_cfg(1'b1, 32'hC000_0001);
        rd_cfg(1'b1, "R2 write-word top bits", 32'h0000_0001);
    endtask

    task automatic t_independent();
        wr_cfg(1'b1, 32'h1234_5678);
        rd_cfg(1'b0, "R3 primary untouched", 32'h3FFF_FFFF);
        rd_cfg(1'b1, "R3 write word updated", 32'h1234_5678);
        wr_cfg(1'b0, 32'h0ABC_DEF0);
        rd_cfg(1'b1, "R3 write word untouched", 32'h1234_5678);
        rd_cfg(1'b0, "R3 primary updated", 32'h0ABC_DEF0);
    endtask

    task automatic t_shared();
        wr_cfg(1'b0, 32'h3000_0AAA);
        wr_cfg(1'b1, 32'h1000_0555);
        ext_mode = 1'b0;
        req_write = 1'b1; #1;
        chk("R4 write uses primary", act_word, 32'h3000_0AAA);
        chk("R6 mode forced A", {30'b0, act_mode}, 32'h0);
        req_write = 1'b0; #1;
        chk("R4 read uses primary", act_word, 32'h3000_0AAA);
    endtask

    task automatic t_split();
        ext_mode = 1'b1;
        req_write = 1'b0; #1;
        chk("R5 read uses primary", act_word, 32'h3000_0AAA);
        chk("R6 read mode D", {30'b0, act_mode}, 32'h3);
        req_write = 1'b1; #1;
        chk("R5 write uses write word", act_word, 32'h1000_0555);
        chk("R6 write mode B", {30'b0, act_mode}, 32'h1);
        req_write = 1'b0;
        for (int m = 0; m < 4; m++) begin
            wr_cfg(1'b0, {2'b11, 2'(m), 28'h0345_678});
            #1;
            chk("R6 mode field decode", {30'b0, act_mode}, 32'(m));
            chk("R2 masked in act_word", act_word, {2'b00, 2'(m), 28'h0345_678});
        end
        ext_mode = 1'b0;
    endtask

    task automatic t_gap(input int f);
        wr_cfg(1'b0, 32'(f) << 16);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_mux = 1'b1;
        #1;
        chk("R7 mux read granted at once", {31'b0, grant}, 32'h1);
        @(negedge clk);
        req_write = 1'b1;
        for (int i = 0; i < f + 1; i++) begin
            #1;
            chk($sformatf("R8 gap cycle %0d of %0d", i + 1, f + 1), {31'b0, grant}, 32'h0);
            @(negedge clk);
        end
        #1;
        chk("R10 held request granted after gap", {31'b0, grant}, 32'h1);
        @(negedge clk);
        #1;
        chk("R9 no gap after write", {31'b0, grant}, 32'h1);
        req_valid = 1'b0; req_mux = 1'b0; req_write = 1'b0;
    endtask

    task automatic t_no_gap();
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_mux = 1'b0;
        for (int i = 0; i < 3; i++) begin
            #1;
            chk("R9 plain read back-to-back", {31'b0, grant}, 32'h1);
            @(negedge clk);
        end
        req_valid = 1'b0; #1;
        chk("R7 no grant without request", {31'b0, grant}, 32'h0);
    endtask

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
        ext_mode = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_mux = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_reserved();
        t_independent();
        t_shared();
        t_split();
        t_gap(0);
        t_gap(5);
        t_gap(15);
        t_no_gap();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule